// File: doc/BRIEF.md
# Bit-Slice Data Routing Matrix

This block moves single bits from sixteen 8-bit source shift registers into sixteen 8-bit destination shift registers, under a source address and a destination address supplied from outside. The sources form two banks of eight. Each bank has a 3-bit channel index, and each bank can be switched off on its own. The one bank left on places the most significant bit of its chosen register on a shared one-bit bus. A 1-of-16 distributor then shifts that bus bit into the single destination register that the destination address names.

A controller can step the source address eight times for every shift of the sources. In that case the current top bit of every register in a bank is gathered before the next bit moves up. Routing each such round into a different destination gives a corner turn of the data: the top bits of all sources land in one destination, the next bits in the next destination, and so on. Other slicing patterns follow from other address sequences.

The source and destination addresses, the bank switches and the transfer strobe are registered at the block's edge. A transfer requested at one clock edge shows its bus bit during the following cycle and is written at the next edge. Transfers can be issued every cycle.

Top module: `bitslice_router`

## Requirements
- R1: After a synchronous active-low reset, every source and destination register holds 0, both banks are off, no transfer is pending, and `bus_bit` is 0.
- R2: When exactly one bank is on, `bus_bit` carries bit 7 (the MSB) of source register `bank*8 + chan`. Bank 0 holds sources 0 to 7 and bank 1 holds sources 8 to 15. Bit `b` of `bank_off` set to 1 switches bank `b` off.
- R3: A transfer writes only destination register `dst_sel`. That register shifts left by one, bit 0 takes the bus bit, and the old bit 7 is dropped. Every other destination register keeps its value.
- R4: A source register with its `src_load` bit set takes its slice of `src_load_data`, and this load wins over `src_shift`. When `src_shift` is high, every source register that is not loading shifts left by one and bit 0 takes 0.
- R5: When both banks are off, `bus_bit` is 0 and no destination register changes, even with `xfer_valid` high.
- R6: When both banks are on (bus contention), `bus_bit` is 0 and no destination register changes.
- R7: The addresses, bank switches and `xfer_valid` are sampled at clock edge k. `bus_bit` shows the selected bit during the cycle after edge k. The destination register is written at edge k+1. A new transfer may be requested at every edge.
- R8: A source shift sampled at the same edge as a destination write does not change the bit written. The write takes the MSB held before that shift.
- R9: With `xfer_valid` low at the sampling edge, no destination register changes, whatever the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_load | input | 16 | Per-source parallel load request |
| src_load_data | input | 128 | Load values; source i at bits [8i+7:8i] |
| src_shift | input | 1 | Shift all non-loading sources left by one |
| xfer_valid | input | 1 | Transfer request strobe |
| bank_off | input | 2 | Per-bank disable; bit 0 = sources 0-7, bit 1 = sources 8-15 |
| chan_sel | input | 3 | Channel within the enabled bank |
| dst_sel | input | 4 | Destination register index |
| bus_bit | output | 1 | Shared one-bit bus value |
| dst_data | output | 128 | Destination contents; register d at bits [8d+7:8d] |

## Verification
Two functions can fall on the same clock edge. One is a source shift (or a parallel load). The other is the destination write that reads that same source's MSB. The bench provokes this by asserting `src_shift` during the cycle in which a captured transfer is pending. It also runs a full eight-round corner turn in which the shift request shares the edge of each round's last write. The bench judges the result by comparing every destination register against a model that takes the pre-shift MSB. A model that took the post-shift bit would disagree in the written bit.

// File: rtl/bsr_pkg.sv
// Shared constants for the bit-slice router.
// Assumes: two banks of eight 8-bit sources and sixteen destinations by default.
package bsr_pkg;
    localparam int unsigned DEF_BANKS      = 2;
    localparam int unsigned DEF_BANK_DEPTH = 8;
    localparam int unsigned DEF_REG_W      = 8;
    localparam int unsigned DEF_NUM_DST    = 16;
endpackage

// File: rtl/bsr_src_bank.sv
// One bank of source shift registers with its channel selector.
// Each register loads in parallel (priority) or shifts left with zero fill.
// Outputs the MSB of the register picked by chan.
// Assumes chan is already registered by the caller.
module bsr_src_bank #(
    parameter int unsigned DEPTH = bsr_pkg::DEF_BANK_DEPTH,
    parameter int unsigned W     = bsr_pkg::DEF_REG_W,
    localparam int unsigned CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] load,
    input  logic [DEPTH*W-1:0] load_data,
    input  logic             shift,
    input  logic [CW-1:0]    chan,
    output logic             msb_out
);
    logic [W-1:0] regs [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_reg
            // Per-register load/shift update.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gi] <= '0;
                else if (load[gi])
                    regs[gi] <= load_data[gi*W +: W];
                else if (shift)
                    regs[gi] <= {regs[gi][W-2:0], 1'b0};
            end

            // R4: a load lands its data at the next edge.
            assert_load_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
                load[gi] |=> regs[gi] == $past(load_data[gi*W +: W]));
        end
    endgenerate

    // Channel selector: MSB of the addressed register.
    always_comb begin
        msb_out = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (chan == CW'(i))
                msb_out = regs[i][W-1];
    end
endmodule

// File: rtl/bsr_ctl_latch.sv
// Edge register stage for transfer addresses and strobe.
// On reset all banks are off and no transfer is pending.
module bsr_ctl_latch #(
    parameter int unsigned BANKS = bsr_pkg::DEF_BANKS,
    parameter int unsigned CW    = 3,
    parameter int unsigned DW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [BANKS-1:0] off_in,
    input  logic [CW-1:0]    chan_in,
    input  logic [DW-1:0]    dst_in,
    output logic             valid_q,
    output logic [BANKS-1:0] off_q,
    output logic [CW-1:0]    chan_q,
    output logic [DW-1:0]    dst_q
);
    // Capture the request every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            off_q   <= '1;
            chan_q  <= '0;
            dst_q   <= '0;
        end else begin
            valid_q <= valid_in;
            off_q   <= off_in;
            chan_q  <= chan_in;
            dst_q   <= dst_in;
        end
    end
endmodule

// File: rtl/bsr_dist_decoder.sv
// Gated 1-of-N distributor decode.
// Raises one line for sel when en is high; all lines are low otherwise.
module bsr_dist_decoder #(
    parameter int unsigned N  = bsr_pkg::DEF_NUM_DST,
    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  line
);
    // Decode the destination index.
    always_comb begin
        line = '0;
        for (int i = 0; i < N; i++)
            if (en && sel == SW'(i))
                line[i] = 1'b1;
    end

    // R3: at most one destination line per transfer.
    assert_single_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line));
endmodule

// File: rtl/bsr_dst_file.sv
// Destination shift registers.
// The register whose line is high shifts left and takes the bus bit into bit 0.
module bsr_dst_file #(
    parameter int unsigned N = bsr_pkg::DEF_NUM_DST,
    parameter int unsigned W = bsr_pkg::DEF_REG_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   line,
    input  logic           bus,
    output logic [N*W-1:0] data
);
    logic [W-1:0] regs [N];

    genvar gd;
    generate
        for (gd = 0; gd < N; gd++) begin : g_dst
            // Shift in the bus bit when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gd] <= '0;
                else if (line[gd])
                    regs[gd] <= {regs[gd][W-2:0], bus};
            end

            assign data[gd*W +: W] = regs[gd];

            // R3: an unaddressed register holds its value.
            assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !line[gd] |=> $stable(regs[gd]));

            // R3: an addressed register takes the bus bit into bit 0.
            assert_bus_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
                line[gd] |=> regs[gd][0] == $past(bus));
        end
    endgenerate
endmodule

// File: rtl/bitslice_router.sv
// Bit-slice routing matrix top level.
// Source banks feed a shared one-bit bus. Only a single enabled bank may
// drive it; a quiet or contended bus reads 0 and blocks writes. A registered
// destination address steers the bus bit into one destination register.
module bitslice_router #(
    parameter int unsigned BANKS      = bsr_pkg::DEF_BANKS,
    parameter int unsigned BANK_DEPTH = bsr_pkg::DEF_BANK_DEPTH,
    parameter int unsigned REG_W      = bsr_pkg::DEF_REG_W,
    parameter int unsigned NUM_DST    = bsr_pkg::DEF_NUM_DST,
    localparam int unsigned NUM_SRC   = BANKS * BANK_DEPTH,
    localparam int unsigned CW        = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1,
    localparam int unsigned DW        = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_load,
    input  logic [NUM_SRC*REG_W-1:0] src_load_data,
    input  logic                     src_shift,
    input  logic                     xfer_valid,
    input  logic [BANKS-1:0]         bank_off,
    input  logic [CW-1:0]            chan_sel,
    input  logic [DW-1:0]            dst_sel,
    output logic                     bus_bit,
    output logic [NUM_DST*REG_W-1:0] dst_data
);
    logic             valid_q;
    logic [BANKS-1:0] off_q;
    logic [CW-1:0]    chan_q;
    logic [DW-1:0]    dst_q;
    logic [BANKS-1:0] bank_msb;
    logic             bus_ok;
    logic             wr_en;
    logic [NUM_DST-1:0] line;

    bsr_ctl_latch #(.BANKS(BANKS), .CW(CW), .DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .valid_in(xfer_valid), .off_in(bank_off),
        .chan_in(chan_sel), .dst_in(dst_sel),
        .valid_q(valid_q), .off_q(off_q), .chan_q(chan_q), .dst_q(dst_q)
    );

    genvar gb;
    generate
        for (gb = 0; gb < BANKS; gb++) begin : g_bank
            bsr_src_bank #(.DEPTH(BANK_DEPTH), .W(REG_W)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .load(src_load[gb*BANK_DEPTH +: BANK_DEPTH]),
                .load_data(src_load_data[gb*BANK_DEPTH*REG_W +: BANK_DEPTH*REG_W]),
                .shift(src_shift),
                .chan(chan_q),
                .msb_out(bank_msb[gb])
            );
        end
    endgenerate

    // Bus merge: exactly one enabled bank drives, otherwise the bus reads 0.
    always_comb begin
        bus_ok  = ($countones(~off_q) == 1);
        bus_bit = 1'b0;
        if (bus_ok)
            for (int b = 0; b < BANKS; b++)
                if (!off_q[b])
                    bus_bit = bank_msb[b];
    end

    // A write needs a valid request and a cleanly driven bus.
    assign wr_en = valid_q && bus_ok;

    bsr_dist_decoder #(.N(NUM_DST)) u_dec (
        .clk(clk), .rst_n(rst_n), .en(wr_en), .sel(dst_q), .line(line)
    );

    bsr_dst_file #(.N(NUM_DST), .W(REG_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .line(line), .bus(bus_bit), .data(dst_data)
    );

    // R5: all banks off leaves the bus low and blocks writes.
    assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&off_q) |-> (!bus_bit && line == '0));

    // R6: two or more banks on is contention: bus low, no write.
    assert_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~off_q) > 1) |-> (!bus_bit && line == '0));

    // R9: no captured request, no destination line.
    assert_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> line == '0);
endmodule

// File: tb/bitslice_router_bench.sv
module bitslice_router_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [15:0]  src_load;
    logic [127:0] src_load_data;
    logic         src_shift;
    logic         xfer_valid;
    logic [1:0]   bank_off;
    logic [2:0]   chan_sel;
    logic [3:0]   dst_sel;
    logic         bus_bit;
    logic [127:0] dst_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state, written from the requirements.
    logic [7:0] m_src [16];
    logic [7:0] m_dst [16];
    logic       m_valid;
    logic [1:0] m_off;
    logic [2:0] m_chan;
    logic [3:0] m_dsel;

    always #5 clk = ~clk;

    bitslice_router u_bitslice_router (
        .clk(clk), .rst_n(rst_n), .src_load(src_load), .src_load_data(src_load_data),
        .src_shift(src_shift), .xfer_valid(xfer_valid), .bank_off(bank_off),
        .chan_sel(chan_sel), .dst_sel(dst_sel), .bus_bit(bus_bit), .dst_data(dst_data)
    );

    function automatic logic m_ok();
        return (m_off == 2'b01) || (m_off == 2'b10);
    endfunction

    function automatic logic m_bus();
        if (!m_ok()) return 1'b0;
        return m_src[(m_off[0] ? 8 : 0) + int'(m_chan)][7];
    endfunction

    function automatic logic [127:0] m_flat();
        logic [127:0] f;
        for (int i = 0; i < 16; i++) f[i*8 +: 8] = m_dst[i];
        return f;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s bus_bit act %b exp %b", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dst_data act %h exp %h", tag, act, exp);
        end
    endtask

    // One clock: model update at the edge, clear strobes, compare at negedge.
    task automatic tick(string tag);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin m_src[i] = '0; m_dst[i] = '0; end
            m_valid = 0; m_off = 2'b11; m_chan = '0; m_dsel = '0;
        end else begin
            logic b;
            b = m_bus();
            if (m_valid && m_ok()) m_dst[m_dsel] = {m_dst[m_dsel][6:0], b};
            for (int i = 0; i < 16; i++)
                if (src_load[i]) m_src[i] = src_load_data[i*8 +: 8];
                else if (src_shift) m_src[i] = {m_src[i][6:0], 1'b0};
            m_valid = xfer_valid; m_off = bank_off; m_chan = chan_sel; m_dsel = dst_sel;
        end
        @(negedge clk);
        src_load = '0; src_shift = 0; xfer_valid = 0;
        check_bit(tag, bus_bit, m_bus());
        check_vec(tag, dst_data, m_flat());
    endtask

    task automatic req(int src, int dst, logic v);
        xfer_valid = v;
        bank_off   = (src >= 8) ? 2'b01 : 2'b10;
        chan_sel   = 3'(src % 8);
        dst_sel    = 4'(dst);
    endtask

    task automatic load_all(int seed);
        src_load = '1;
        for (int i = 0; i < 16; i++) src_load_data[i*8 +: 8] = 8'((i * 37 + seed) ^ (i << 3));
    endtask

    task automatic t_reset();
        rst_n = 0;
        tick("R1"); tick("R1");
        rst_n = 1;
        check_vec("R1", dst_data, '0);
        check_bit("R1", bus_bit, 1'b0);
        req(5, 3, 1); tick("R1"); tick("R1");   // reset sources give a 0 bit
    endtask

    task automatic t_single();
        load_all(11); tick("R4");
        req(3, 2, 1);   tick("R2");
        req(12, 15, 1); tick("R7");
        tick("R3");
        check_bit("R2", m_dst[2][0], m_src[3][7]);
    endtask

    task automatic t_back2back();
        for (int k = 0; k < 16; k++) begin req(15 - k, k, 1); tick("R7"); end
        tick("R7");
    endtask

    task automatic t_valid_low();
        for (int k = 0; k < 4; k++) begin req(k * 3, k + 4, 0); tick("R9"); end
        tick("R9");
    endtask

    task automatic t_banks();
        req(2, 6, 1); bank_off = 2'b11; tick("R5"); tick("R5");
        req(9, 7, 1); bank_off = 2'b00; tick("R6"); tick("R6");
    endtask

    task automatic t_load_prio();
        load_all(90); tick("R4");
        src_shift = 1; src_load = 16'h00F0;
        for (int i = 0; i < 16; i++) src_load_data[i*8 +: 8] = 8'h81;
        tick("R4");
        for (int s = 0; s < 16; s++) begin req(s, s, 1); tick("R4"); end
        tick("R4");
    endtask

    task automatic t_shift_xfer();
        load_all(5); tick("R8");
        req(6, 9, 1); tick("R8");
        src_shift = 1; tick("R8");               // shift shares the write edge
        req(6, 9, 1); tick("R8"); tick("R8");
    endtask

    task automatic t_transpose();
        logic [7:0] exp0;
        src_load = 16'h00FF;
        for (int i = 0; i < 8; i++) src_load_data[i*8 +: 8] = 8'h80 >> i;
        tick("R8");
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 8; s++) begin
                req(s, k, 1);
                if (s == 0 && k > 0) src_shift = 1;
                tick("R8");
            end
        end
        tick("R8");
        // Source s holds a single 1 at bit 7-s, so slice k receives a 1 from source k.
        for (int k = 0; k < 8; k++) begin
            exp0 = 8'h80 >> k;
            check_vec("R8", {120'd0, dst_data[k*8 +: 8]}, {120'd0, exp0});
        end
    endtask

    initial begin
        rst_n = 0; src_load = '0; src_load_data = '0; src_shift = 0;
        xfer_valid = 0; bank_off = 2'b11; chan_sel = '0; dst_sel = '0;
        @(negedge clk);
        t_reset();
        t_single();
        t_back2back();
        t_valid_low();
        t_banks();
        t_load_prio();
        t_shift_xfer();
        t_transpose();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule